// File: doc/BRIEF.md
# Multiplexed Pulse High-Time Timer

This block measures how long one of four level signals stays high. The unit of measurement is a slow time base taken from the system clock. A free-running prescaler divides the clock by 2^PRESC_W, which is 128 by default. Its rising most-significant bit is turned into a tick one clock wide. That tick, ANDed with the selected channel, is the count enable of a saturating counter. Every register runs on the one system clock, and no clock is ever gated.

A select input picks the channel. When the selected signal falls, the accumulated count is copied into a result register, a valid strobe pulses for one cycle, and the counter starts again from zero. If the select changes, the counter is cleared and measurement stays suspended until the newly chosen input has been seen low. This means a pulse that was already under way when the channel changed is never reported.

Top module: `pulse_hightime_timer`

## Requirements
- R1: The time-base tick is high for exactly one cycle in every 2^PRESC_W cycles. Number the cycles from 0, where cycle 0 ends at the first rising edge with reset low. The tick then falls in every cycle whose number modulo 2^PRESC_W equals 2^(PRESC_W-1), which is 64 by default.
- R2: A reported count equals the number of tick cycles during which the selected input was high. Any high cycle that is not a tick cycle adds nothing.
- R3: A select value n routes bit n of `sig_in` to the counter. Pulses on the unselected bits produce no strobe and leave the next count unchanged.
- R4: Take the first cycle in which the selected input is low after being high. At the clock edge that ends that cycle, `hi_count` loads the count and `hi_valid` rises. `hi_valid` stays high for exactly one cycle.
- R5: The counter returns to zero when a result is captured, so each pulse is measured from zero.
- R6: A change of `chan_sel` clears the counter. No result is reported for any high period of the newly selected input that began before that input was seen low. `hi_count` keeps its previous value until a full pulse is captured.
- R7: The counter holds at all ones (2^CNT_W-1) instead of wrapping.
- R8: Synchronous reset clears `hi_count`, `hi_valid`, the counter, the prescaler phase and the stored select. After reset, the selected input must be seen low before a pulse is measured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | NCH | Level signals synchronous to clk, one per channel |
| chan_sel | input | SEL_W | Channel select |
| hi_count | output | CNT_W | Last captured high time in ticks |
| hi_valid | output | 1 | One-cycle strobe when hi_count is loaded |

## Verification
The case hardest to reach is a channel switch while a pulse is being measured and the newly selected input is already high. Only here does the arming rule decide whether a partial period leaks out as a result. The bench creates it by raising two channels and moving the select to the second channel in the middle of a pulse. It then lowers both and checks that no strobe appears. It also checks that the next full pulse gives an exact count. Saturation is reached by shrinking the counter width through its parameter, so that a pulse of twenty ticks overflows it.

// File: rtl/pht_pkg.sv
package pht_pkg;

  // Per-cycle command to the high-time counter.
  typedef struct packed {
    logic clear;  // channel changed: drop any partial count
    logic load;   // selected input fell: capture and restart
    logic step;   // tick while the selected input is high
  } cnt_ctl_t;

endpackage

// File: rtl/pht_tick_gen.sv
module pht_tick_gen #(
  parameter int PRESC_W = 7
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  logic [PRESC_W-1:0] presc_q;
  logic               msb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      msb_q   <= 1'b0;
    end else begin
      presc_q <= presc_q + PRESC_W'(1);
      msb_q   <= presc_q[PRESC_W-1];
    end
  end

  // One-cycle pulse on the rising edge of the prescaler top bit.
  assign tick_o = presc_q[PRESC_W-1] & ~msb_q;

endmodule

// File: rtl/pht_chan_front.sv
module pht_chan_front
  import pht_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   sig_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  output cnt_ctl_t         ctl_o
);

  logic [SEL_W-1:0] sel_q;
  logic [NCH-1:0]   hit;
  logic             lvl;
  logic             lvl_q;
  logic             armed_q;
  logic             chg;

  // AND-OR multiplexer on the registered select.
  for (genvar g = 0; g < NCH; g++) begin : g_mux
    assign hit[g] = sig_i[g] & (sel_q == SEL_W'(g));
  end
  assign lvl = |hit;
  assign chg = (sel_i != sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      lvl_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      lvl_q <= lvl;
      if (chg)       armed_q <= 1'b0;
      else if (!lvl) armed_q <= 1'b1;
    end
  end

  always_comb begin
    ctl_o.clear = chg;
    ctl_o.load  = !chg && armed_q && lvl_q && !lvl;
    ctl_o.step  = !chg && armed_q && lvl && tick_i;
  end

endmodule

// File: rtl/pht_counter.sv
module pht_counter
  import pht_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_ctl_t         ctl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] res_o,
  output logic             vld_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] res_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ctl_i.load;
      if (ctl_i.clear) begin
        cnt_q <= '0;
      end else if (ctl_i.load) begin
        res_q <= cnt_q;
        cnt_q <= '0;
      end else if (ctl_i.step && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o = cnt_q;
  assign res_o = res_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/pulse_hightime_timer.sv
module pulse_hightime_timer
  import pht_pkg::*;
#(
  parameter  int NCH     = 4,
  parameter  int PRESC_W = 7,
  parameter  int CNT_W   = 16,
  localparam int SEL_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   sig_in,
  input  logic [SEL_W-1:0] chan_sel,
  output logic [CNT_W-1:0] hi_count,
  output logic             hi_valid
);

  logic             tick;
  cnt_ctl_t         ctl;
  logic [CNT_W-1:0] cnt_val;

  pht_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  pht_chan_front #(.NCH(NCH), .SEL_W(SEL_W)) u_front (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (sig_in),
    .sel_i  (chan_sel),
    .tick_i (tick),
    .ctl_o  (ctl)
  );

  pht_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .ctl_i (ctl),
    .cnt_o (cnt_val),
    .res_o (hi_count),
    .vld_o (hi_valid)
  );

endmodule

// File: rtl/pht_checker.sv
module pht_checker #(
  parameter int PRESC_W = 7,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             clr,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] result,
  input logic             valid
);

  localparam int               PERIOD  = 2 ** PRESC_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRESC_W:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_tick_width_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && seen_q) |-> (int'(gap_q) == PERIOD - 1));

  p_step_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    ((cnt != $past(cnt)) && (cnt != '0)) |-> $past(tick));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_clear_after_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0) && valid);

  p_clear_on_change_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && !valid);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX) || (cnt == '0));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !valid && (result == '0));

endmodule

bind pulse_hightime_timer pht_checker #(
  .PRESC_W (PRESC_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .clr    (ctl.clear),
  .load   (ctl.load),
  .cnt    (cnt_val),
  .result (hi_count),
  .valid  (hi_valid)
);

// File: tb/test_pulse_hightime_timer.sv
`timescale 1ns/1ps
module test_pulse_hightime_timer;

  localparam int CW  = 4;    // narrow counter so saturation is reachable
  localparam int PER = 128;
  localparam int NV  = 8;

  // channel, start phase, high cycles, expected ticks
  localparam int T_CH  [NV] = '{0, 1, 2, 3, 0, 2, 1, 3};
  localparam int T_PH  [NV] = '{0, 60, 65, 64, 10, 64, 63, 65};
  localparam int T_LEN [NV] = '{128, 10, 127, 129, 600, 1, 1, 1};
  localparam int T_EXP [NV] = '{1, 1, 0, 2, 5, 1, 0, 0};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    sig = '0;
  logic [1:0]    sel = '0;
  logic [CW-1:0] hi_count;
  logic          hi_valid;

  int cyc    = 0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pulse_hightime_timer #(.NCH(4), .PRESC_W(7), .CNT_W(CW)) i_pulse_hightime_timer (
    .clk      (clk),
    .rst      (rst),
    .sig_in   (sig),
    .chan_sel (sel),
    .hi_count (hi_count),
    .hi_valid (hi_valid)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic wait_phase(input int p);
    while ((cyc % PER) != p) step();
  endtask

  task automatic run_pulse(input int ch, input int p, input int len, input int exp, input string req);
    sel = 2'(ch);
    sig = '0;
    step();
    step();
    wait_phase(p);
    sig[ch] = 1'b1;
    repeat (len) step();
    sig[ch] = 1'b0;
    step();
    chk(req, "valid after fall", int'(hi_valid), 1);
    chk(req, "count", int'(hi_count), exp);
    step();
    chk("R4", "valid one cycle", int'(hi_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "count in reset", int'(hi_count), 0);
    chk("R8", "valid in reset", int'(hi_valid), 0);
    rst = 1'b0;
    cyc = 0;

    // Table walk: R1 phase, R2 counting, R3 routing, R4/R5 capture.
    for (int i = 0; i < NV; i++) begin
      run_pulse(T_CH[i], T_PH[i], T_LEN[i], T_EXP[i], "R2");
    end

    // R3: unselected channel has no effect.
    sel = 2'd0; sig = '0; step(); step();
    wait_phase(0);
    sig[3] = 1'b1;
    repeat (200) step();
    sig[3] = 1'b0;
    step();
    chk("R3", "no strobe from other channel", int'(hi_valid), 0);
    step();
    run_pulse(0, 64, 1, 1, "R3");

    // R6: switch mid-pulse onto a channel that is already high.
    sel = 2'd1; sig = '0; step(); step();
    wait_phase(0);
    sig[1] = 1'b1;
    repeat (100) step();
    sig[2] = 1'b1;
    sel = 2'd2;
    repeat (200) step();
    sig = '0;
    step();
    chk("R6", "no strobe for partial", int'(hi_valid), 0);
    step();
    chk("R6", "no late strobe", int'(hi_valid), 0);
    chk("R6", "result held", int'(hi_count), 1);
    run_pulse(2, 64, 1, 1, "R6");

    // R6: switch mid-pulse onto a low channel, then count from zero.
    sel = 2'd3; sig = '0; step(); step();
    wait_phase(0);
    sig[3] = 1'b1;
    repeat (300) step();
    sel = 2'd0;
    step();
    sig[3] = 1'b0;
    step();
    chk("R6", "old channel fall ignored", int'(hi_valid), 0);
    run_pulse(0, 60, 10, 1, "R5");

    // R7: saturation at all ones.
    run_pulse(0, 0, 20 * PER, 15, "R7");
    run_pulse(0, 64, 1, 1, "R5");

    // R8: reset mid-pulse clears everything and restarts the phase.
    sel = 2'd0; sig = '0; step(); step();
    wait_phase(60);
    sig[0] = 1'b1;
    repeat (10) step();
    rst = 1'b1;
    step();
    step();
    chk("R8", "count after reset", int'(hi_count), 0);
    chk("R8", "valid after reset", int'(hi_valid), 0);
    rst = 1'b0;
    cyc = 0;
    repeat (5) step();
    sig[0] = 1'b0;
    step();
    chk("R8", "no strobe before arming", int'(hi_valid), 0);
    step();
    run_pulse(0, 64, 1, 1, "R1");
    run_pulse(0, 63, 1, 0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule